// File: doc/BRIEF.md
# Scan Decimating Sample Stream Filter

The block sits between a sample FIFO and a downstream consumer. Its input is a stream of conversions taken at one fixed pace. Its output is scan-rate data. The single pacer has to produce a scan period longer than one pass over the channels, so the block emulates that period in software-free hardware. It groups consecutive samples into chunks of `scan_len_i × (1 + skip_i)`. From each chunk it forwards the first `scan_len_i` samples and silently consumes the rest.

Every forwarded word is converted from the converter's two's-complement raw format to offset binary, at the converter's native width. In counted mode the block counts every consumed sample against a total of `stop_scans_i` whole chunks, and then raises end of acquisition. In continuous mode it runs until the next start. A start pulse captures all configuration.

Top module: `scan_decim_top`

## Requirements
- R1: Out of reset, and until the first start pulse, `in_ready_o`, `out_valid_o` and `eoa_o` are all 0. A start pulse clears `eoa_o` and takes effect in the next cycle. In the start cycle itself, no input is accepted.
- R2: After a start, a position counter starts at 0. It advances by one on every accepted input sample (`in_valid_i && in_ready_o`) and wraps to 0 after position `scan_len × (1 + skip) − 1`. `scan_len_i` must be nonzero.
- R3: An input at a position below `scan_len` is forwarded in the same cycle. `out_valid_o` equals `in_valid_i`, and `in_ready_o` follows `out_ready_i`.
- R4: An input at a position of `scan_len` or above is dropped. `out_valid_o` stays 0 and `in_ready_o` is 1 whatever the value of `out_ready_i`.
- R5: With `skip_i = 0`, every input sample is forwarded, in arrival order.
- R6: In counted mode (`cont_i = 0` at start), the block accepts exactly `stop_scans × scan_len × (1 + skip)` samples, counting dropped samples as well as forwarded ones. `eoa_o` rises in the cycle after the last one, and `in_ready_o` stays 0 from then on. With `stop_scans_i = 0`, `eoa_o` rises in the cycle after the start and nothing is accepted.
- R7: In continuous mode (`cont_i = 1` at start), `eoa_o` never rises and input is accepted indefinitely.
- R8: The output word, with ADC_BITS = 12, is `((raw >> 4) & 0xFFF) ^ 0x800`. Examples: raw 0x0000 gives 0x800, raw 0x7FF0 gives 0xFFF, raw 0x8000 gives 0x000, and raw 0xFFFF gives 0x7FF. With ADC_BITS = 16, the raw word is not shifted and bit 15 is inverted.
- R9: Changes to `scan_len_i`, `skip_i`, `stop_scans_i` or `cont_i` after a start have no effect until the next start.
- R10: A start pulse during a run restarts the run, with fresh configuration, position 0 and a fresh stop total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; captures configuration |
| scan_len_i | input | SCAN_W | Samples per scan (nonzero) |
| skip_i | input | SKIP_W | Whole scans to drop after each kept scan |
| stop_scans_i | input | STOP_W | Kept scans before end of acquisition |
| cont_i | input | 1 | 1 = continuous, 0 = counted |
| in_valid_i | input | 1 | Input sample valid |
| in_data_i | input | RAW_W | Raw converter word |
| in_ready_o | output | 1 | Input sample accepted when high with valid |
| out_valid_o | output | 1 | Forwarded sample valid |
| out_data_o | output | ADC_BITS | Offset-binary sample |
| out_ready_i | input | 1 | Consumer ready |
| eoa_o | output | 1 | End of acquisition |

## Verification
The streaming path has no storage. `out_valid_o`, `out_data_o` and `in_ready_o` respond to the inputs in the same cycle, while position, remaining count and `eoa_o` change one clock edge after an accepted sample or a start. The bench therefore drives inputs on the falling edge and compares all four outputs a moment later against a behavioural model. It then advances the model by exactly one edge, so that effects of registered state, such as `eoa_o` or a new configuration, are expected in the cycle after the edge that causes them.

// File: rtl/scan_decim_pkg.sv
package scan_decim_pkg;
  typedef enum logic [1:0] {
    ACQ_IDLE = 2'd0,
    ACQ_RUN  = 2'd1,
    ACQ_DONE = 2'd2
  } acq_state_e;
endpackage

// File: rtl/scan_pos_ctr.sv
module scan_pos_ctr #(
  parameter int SCAN_W  = 4,
  parameter int SKIP_W  = 4,
  parameter int CHUNK_W = SCAN_W + SKIP_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [SCAN_W-1:0]  scan_len_i,
  input  logic [SKIP_W-1:0]  skip_i,
  input  logic               adv_i,
  output logic [CHUNK_W-1:0] chunk_next_o,
  output logic               keep_o
);
  logic [CHUNK_W-1:0] chunk_q, pos_q, pos_d;
  logic [SCAN_W-1:0]  scan_q;

  assign chunk_next_o = CHUNK_W'(scan_len_i) * (CHUNK_W'(skip_i) + CHUNK_W'(1));
  assign keep_o       = pos_q < CHUNK_W'(scan_q);

  always_comb begin
    pos_d = pos_q;
    if (load_i)
      pos_d = '0;
    else if (adv_i)
      pos_d = (pos_q == chunk_q - CHUNK_W'(1)) ? '0 : pos_q + CHUNK_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chunk_q <= '0;
      scan_q  <= '0;
      pos_q   <= '0;
    end else begin
      pos_q <= pos_d;
      if (load_i) begin
        chunk_q <= chunk_next_o;
        scan_q  <= scan_len_i;
      end
    end
  end

  // R2: position stays inside the chunk
  a_r2_pos_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chunk_q != '0) |-> (pos_q < chunk_q));
  // R2: position either steps by one or wraps
  a_r2_pos_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i) |=> ((pos_q == $past(pos_q) + CHUNK_W'(1)) || (pos_q == '0)));
  // R1: start clears position
  a_r1_pos_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (pos_q == '0));
endmodule

// File: rtl/acq_stop_ctr.sv
module acq_stop_ctr
  import scan_decim_pkg::*;
#(
  parameter int STOP_W  = 12,
  parameter int CHUNK_W = 9,
  parameter int CNT_W   = STOP_W + CHUNK_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [STOP_W-1:0]  stop_scans_i,
  input  logic [CHUNK_W-1:0] chunk_i,
  input  logic               cont_i,
  input  logic               consume_i,
  output logic               running_o,
  output logic               eoa_o
);
  acq_state_e       state_q, state_d;
  logic [CNT_W-1:0] rem_q, rem_d, total;
  logic             cont_q;

  assign total = CNT_W'(stop_scans_i) * CNT_W'(chunk_i);

  always_comb begin
    state_d = state_q;
    rem_d   = rem_q;
    if (load_i) begin
      rem_d   = total;
      state_d = (!cont_i && total == '0) ? ACQ_DONE : ACQ_RUN;
    end else if (state_q == ACQ_RUN && consume_i && !cont_q) begin
      rem_d = rem_q - CNT_W'(1);
      if (rem_q == CNT_W'(1)) state_d = ACQ_DONE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ACQ_IDLE;
      rem_q   <= '0;
      cont_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      rem_q   <= rem_d;
      if (load_i) cont_q <= cont_i;
    end
  end

  assign running_o = (state_q == ACQ_RUN);
  assign eoa_o     = (state_q == ACQ_DONE);

  // R6: each counted consumption lowers the total by one
  a_r6_count_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running_o && consume_i && !load_i && !cont_q) |=> (rem_q == $past(rem_q) - CNT_W'(1)));
  // R6: a counted run never sits at zero remaining
  a_r6_run_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running_o && !cont_q) |-> (rem_q != '0));
  // R7: continuous runs stay running until restarted
  a_r7_cont_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running_o && cont_q && !load_i) |=> running_o);
endmodule

// File: rtl/sample_fmt_conv.sv
module sample_fmt_conv #(
  parameter int RAW_W    = 16,
  parameter int ADC_BITS = 12
) (
  input  logic [RAW_W-1:0]    raw_i,
  output logic [ADC_BITS-1:0] data_o
);
  localparam int SHIFT = RAW_W - ADC_BITS;
  logic [ADC_BITS-1:0] aligned;

  generate
    if (SHIFT == 0) begin : g_native
      assign aligned = raw_i;
    end else begin : g_shift
      assign aligned = raw_i[RAW_W-1:SHIFT];
    end
  endgenerate

  // two's complement to offset binary
  assign data_o = {~aligned[ADC_BITS-1], aligned[ADC_BITS-2:0]};
endmodule

// File: rtl/scan_decim_top.sv
module scan_decim_top #(
  parameter int RAW_W    = 16,
  parameter int ADC_BITS = 12,
  parameter int SCAN_W   = 4,
  parameter int SKIP_W   = 4,
  parameter int STOP_W   = 12
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [SCAN_W-1:0]   scan_len_i,
  input  logic [SKIP_W-1:0]   skip_i,
  input  logic [STOP_W-1:0]   stop_scans_i,
  input  logic                cont_i,
  input  logic                in_valid_i,
  input  logic [RAW_W-1:0]    in_data_i,
  output logic                in_ready_o,
  output logic                out_valid_o,
  output logic [ADC_BITS-1:0] out_data_o,
  input  logic                out_ready_i,
  output logic                eoa_o
);
  localparam int CHUNK_W = SCAN_W + SKIP_W + 1;
  localparam int CNT_W   = STOP_W + CHUNK_W;

  logic [CHUNK_W-1:0] chunk_next;
  logic keep, running, open_w, adv;

  assign open_w      = running && !start_i;
  assign out_valid_o = open_w && in_valid_i && keep;
  assign in_ready_o  = open_w && (keep ? out_ready_i : 1'b1);
  assign adv         = in_valid_i && in_ready_o;

  scan_pos_ctr #(.SCAN_W(SCAN_W), .SKIP_W(SKIP_W), .CHUNK_W(CHUNK_W)) u_pos (
    .clk_i, .rst_ni,
    .load_i      (start_i),
    .scan_len_i,
    .skip_i,
    .adv_i       (adv),
    .chunk_next_o(chunk_next),
    .keep_o      (keep)
  );

  acq_stop_ctr #(.STOP_W(STOP_W), .CHUNK_W(CHUNK_W), .CNT_W(CNT_W)) u_stop (
    .clk_i, .rst_ni,
    .load_i      (start_i),
    .stop_scans_i,
    .chunk_i     (chunk_next),
    .cont_i,
    .consume_i   (adv),
    .running_o   (running),
    .eoa_o
  );

  sample_fmt_conv #(.RAW_W(RAW_W), .ADC_BITS(ADC_BITS)) u_fmt (
    .raw_i (in_data_i),
    .data_o(out_data_o)
  );

  // R6: nothing accepted after end of acquisition
  a_r6_eoa_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoa_o |-> !in_ready_o);
  // R3: a stalled forwarded sample is not consumed
  a_r3_backpressure: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |-> !in_ready_o);
  // R4: consumption without consumer ready is a drop
  a_r4_drop_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_ready_o && !out_ready_i) |-> !out_valid_o);
  // R1: start cycle accepts nothing
  a_r1_start_closed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !in_ready_o);
endmodule

// File: tb/tb_scan_decim_top.sv
module tb_scan_decim_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [3:0]  scan_len_i = 4'd1;
  logic [3:0]  skip_i = 4'd0;
  logic [11:0] stop_scans_i = 12'd0;
  logic        cont_i = 1'b0;
  logic        in_valid_i = 1'b0;
  logic [15:0] in_data_i = 16'h0;
  logic        out_ready_i = 1'b0;
  logic        in_ready_o, out_valid_o, eoa_o;
  logic [11:0] out_data_o;

  always #4 clk_i = ~clk_i;

  scan_decim_top dut (.*);

  int vectors = 0, fails = 0;
  string cur_req = "R1";
  int m_state = 0, m_pos = 0, m_scan = 0, m_chunk = 0, m_rem = 0;
  bit m_cont = 0;
  int fwd_q[$];

  function automatic logic [11:0] conv(logic [15:0] r);
    return ((r >> 4) & 16'h0FFF) ^ 16'h0800;
  endfunction

  task automatic cyc(input bit st, input bit iv, input bit ordy, input logic [15:0] d);
    bit keep, e_rdy, e_val, e_eoa, bad;
    @(negedge clk_i);
    start_i = st; in_valid_i = iv; out_ready_i = ordy; in_data_i = d;
    #1;
    keep  = (m_pos < m_scan);
    e_rdy = (m_state == 1) && !st && (keep ? ordy : 1'b1);
    e_val = (m_state == 1) && !st && iv && keep;
    e_eoa = (m_state == 2);
    bad = 0;
    vectors++;
    if (in_ready_o !== e_rdy) begin
      $display("FAIL %s in_ready_o act %b exp %b", cur_req, in_ready_o, e_rdy); bad = 1; end
    if (out_valid_o !== e_val) begin
      $display("FAIL %s out_valid_o act %b exp %b", cur_req, out_valid_o, e_val); bad = 1; end
    if (eoa_o !== e_eoa) begin
      $display("FAIL %s eoa_o act %b exp %b", cur_req, eoa_o, e_eoa); bad = 1; end
    if (e_val && out_data_o !== conv(d)) begin
      $display("FAIL %s out_data_o act %h exp %h", cur_req, out_data_o, conv(d)); bad = 1; end
    if (bad) fails++;
    if (e_val && ordy) fwd_q.push_back(int'(d));
    if (st) begin
      m_scan  = int'(scan_len_i);
      m_chunk = m_scan * (int'(skip_i) + 1);
      m_pos   = 0;
      m_cont  = cont_i;
      m_rem   = int'(stop_scans_i) * m_chunk;
      m_state = (!m_cont && m_rem == 0) ? 2 : 1;
    end else if (iv && e_rdy) begin
      m_pos = (m_pos == m_chunk - 1) ? 0 : m_pos + 1;
      if (!m_cont) begin
        m_rem--;
        if (m_rem == 0) m_state = 2;
      end
    end
  endtask

  task automatic check_lit(input logic [11:0] exp, input string req);
    vectors++;
    if (out_data_o !== exp) begin
      fails++;
      $display("FAIL %s literal out_data_o act %h exp %h", req, out_data_o, exp);
    end
  endtask

  task automatic check_int(input int act, input int exp, input string req);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s count act %0d exp %0d", req, act, exp);
    end
  endtask

  task automatic go(input int sl, input int sk, input int sc, input bit c);
    scan_len_i = 4'(sl); skip_i = 4'(sk); stop_scans_i = 12'(sc); cont_i = c;
    cyc(1, 0, 0, 16'h0);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog act expired exp finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int acc;
    // R1: reset state
    cur_req = "R1";
    repeat (3) cyc(0, 1, 1, 16'h1234);
    @(negedge clk_i); rst_ni = 1'b1;
    repeat (3) cyc(0, 1, 1, 16'h2222);

    // R2 R3 R4 R6: scan 3, skip 2, 2 scans -> 18 samples, backpressure pattern
    cur_req = "R2_R3_R4_R6";
    go(3, 2, 2, 0);
    for (int i = 0; i < 40; i++) cyc(0, 1, (i % 3) != 1, 16'(i * 16'h1357));

    // R5: skip 0 forwards all in order
    cur_req = "R5";
    fwd_q.delete();
    go(4, 0, 3, 0);
    for (int i = 0; i < 20; i++) cyc(0, 1, 1, 16'(16'h0100 + i * 16));
    check_int(fwd_q.size(), 12, "R5");
    acc = 0;
    foreach (fwd_q[k]) if (fwd_q[k] != 16'h0100 + k * 16) acc++;
    check_int(acc, 0, "R5");

    // R7 R9: continuous with gaps; config wiggled mid-run
    cur_req = "R7_R9";
    go(2, 1, 1, 1);
    for (int i = 0; i < 60; i++) begin
      if (i == 10) begin scan_len_i = 4'd5; skip_i = 4'd0; stop_scans_i = 12'd0; cont_i = 1'b0; end
      cyc(0, (i % 4) != 3, (i % 5) != 0, 16'(i * 16'h0F31));
    end

    // R10: restart mid-run with new config
    cur_req = "R10";
    go(3, 1, 4, 0);
    for (int i = 0; i < 7; i++) cyc(0, 1, 1, 16'(i));
    go(2, 0, 2, 0);
    for (int i = 0; i < 8; i++) cyc(0, 1, 1, 16'(16'h4000 + i));

    // R6: zero stop scans ends at once
    cur_req = "R6";
    go(2, 1, 0, 0);
    repeat (4) cyc(0, 1, 1, 16'hAAAA);

    // R8: format corners
    cur_req = "R8";
    go(1, 0, 0, 1);
    cyc(0, 1, 1, 16'h0000); check_lit(12'h800, "R8");
    cyc(0, 1, 1, 16'h7FF0); check_lit(12'hFFF, "R8");
    cyc(0, 1, 1, 16'h8000); check_lit(12'h000, "R8");
    cyc(0, 1, 1, 16'hFFFF); check_lit(12'h7FF, "R8");
    cyc(0, 1, 0, 16'h1230); check_lit(12'h923, "R8");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule